// File: doc/BRIEF.md
# Dual Timer Clock Prescaler with Synchronized Start

This block feeds two timer/counters. For each timer it makes a count-enable pulse. The pulse comes from one of three sources: the system clock itself, one of four divided versions of it, or an edge on an external pin. The divided versions come from one free-running 10-bit counter that both timers share. An external pin is sampled on the system clock, synchronized, and edge-detected. Pin edges never go through the divider.

An 8-bit control register sits on a simple write/read port. It holds a synchronization-mode flag, an input-capture select flag that is only stored, and a prescaler-reset flag. While the synchronization mode is off, setting the reset flag clears the shared divider for one cycle. While the mode is on, the reset flag stays set and both timers stay halted. This lets software load both timers. Clearing the mode then releases both timers on the same clock edge, with the divider starting from zero.

Top module: `tmr_prescale_top`

## Requirements
- R1: After reset the control register reads 0x00 and, with both clock selects at 0, both count-enables are 0.
- R2: Register bit 7 is the synchronization-mode flag, bit 6 the capture-select flag (stored and read back only) and bit 0 the prescaler-reset flag; bits 5..1 always read 0.
- R3: Clock select 0 never produces a count-enable; select 1 gives a count-enable in every cycle in which the prescaler reset is not asserted.
- R4: Selects 2, 3, 4 and 5 give one-cycle count-enable pulses with periods of 8, 64, 256 and 1024 cycles, so any 2048-cycle window holds exactly 256, 32, 8 and 2 pulses.
- R5: Select 7 gives exactly one one-cycle pulse per rising pin edge, and select 6 gives exactly one per falling pin edge. The pulse appears in the second cycle after the pin changes, and the opposite edge produces none. Pin edges are not divided.
- R6: With synchronization mode off, writing 1 to bit 0 resets the divider for one cycle. The bit reads 0 again one cycle later, and the first divide-by-8 pulse follows 8 cycles after the write edge.
- R7: With synchronization mode on, a written 1 in bit 0 stays set with no further writes. While it is set, both count-enables are 0 for every select, including select 1 and pin edges.
- R8: Writing the register with bit 7 = 0 clears bit 0 at that edge. Timers on the same select then produce identical enables, and the first divide-by-8 pulse comes 7 cycles after the releasing write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken on a rising clock edge |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| ext_pin0 | input | 1 | External clock pin for timer 0 |
| ext_pin1 | input | 1 | External clock pin for timer 1 |
| clk_sel0 | input | 3 | Clock select for timer 0 |
| clk_sel1 | input | 3 | Clock select for timer 1 |
| cnt_en0 | output | 1 | Count-enable pulse for timer 0 |
| cnt_en1 | output | 1 | Count-enable pulse for timer 1 |

## Verification
The hardest condition to reach is a halted pair of timers that is released on one edge. Reaching it needs a write that turns on synchronization mode and sets the reset flag together, followed by a later write that leaves the mode. Pin toggles and select changes happen in between. The bench first holds both timers with select 1 and a toggling pin, and checks that no enable appears during the hold. It then puts both timers on the same tap, releases them, and compares the two enables cycle by cycle. It also checks that the first pulse lands exactly 7 cycles after the release edge. A separate one-shot reset outside the mode gives the 8-cycle offset, so the two release paths can be told apart.

// File: rtl/tmr_prescale_pkg.sv
// Shared constants and the clock-select encoding for the timer prescaler.
package tmr_prescale_pkg;

    // Clock-select encoding used by both timers.
    typedef enum logic [2:0] {
        CS_OFF      = 3'd0,
        CS_FULL     = 3'd1,
        CS_DIV_A    = 3'd2,
        CS_DIV_B    = 3'd3,
        CS_DIV_C    = 3'd4,
        CS_DIV_D    = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    localparam int NUM_TAPS  = 4;
    localparam int NUM_TMRS  = 2;
    localparam int REG_W     = 8;

    // Bit positions in the control register.
    localparam int BIT_SYNC  = 7;
    localparam int BIT_CAP   = 6;
    localparam int BIT_PRST  = 0;

    // Divider tap exponent for tap index i (divide by 2**exp).
    function automatic int tap_exp(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_ctrl_reg.sv
// Control register: sync-mode flag, stored capture-select flag, and the
// prescaler-reset flag.
// Assumes: one register, so there is no address; a write is taken on the
// rising edge when wr_en is high.
module tmr_ctrl_reg
    import tmr_prescale_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             presc_hold
);
    logic sync_q;
    logic cap_q;
    logic prst_q;

    // Register update: writes load all three flags; outside sync mode the
    // reset flag clears itself one cycle after being set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            cap_q  <= 1'b0;
            prst_q <= 1'b0;
        end else if (wr_en) begin
            sync_q <= wr_data[BIT_SYNC];
            cap_q  <= wr_data[BIT_CAP];
            prst_q <= wr_data[BIT_PRST];
        end else if (!sync_q) begin
            prst_q <= 1'b0;
        end
    end

    // Read-back image with the unused bits tied to zero.
    always_comb begin
        rd_data           = '0;
        rd_data[BIT_SYNC] = sync_q;
        rd_data[BIT_CAP]  = cap_q;
        rd_data[BIT_PRST] = prst_q;
    end

    assign presc_hold = prst_q;

endmodule

// File: rtl/tmr_divider.sv
// Shared free-running divider with one-cycle tap pulses.
// Assumes: CNT_W covers the largest tap exponent. A tap fires in the cycle
// when its low counter bits are all ones, which is the cycle before they
// wrap to zero. clr holds the counter at zero.
module tmr_divider
    import tmr_prescale_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] tap_pulse
);
    logic [CNT_W-1:0] cnt_q;

    // Free-running count, forced to zero by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // One pulse decoder per tap.
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int EXP = tap_exp(t);
        if (EXP > CNT_W) begin : g_bad
            $error("divider too narrow for tap");
        end
        assign tap_pulse[t] = &cnt_q[EXP-1:0];
    end

endmodule

// File: rtl/tmr_pin_sampler.sv
// External pin sampler: a synchronizer chain plus one edge register, giving
// one-cycle rise and fall pulses.
// Assumes: each pin phase lasts longer than one clock, so pin frequency is
// below half the system clock.
module tmr_pin_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the pin through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Compare the synchronized level with the previous one to find edges.
    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
    assign fall = ~sync_q[SYNC_STAGES-1] & last_q;

endmodule

// File: rtl/tmr_src_select.sv
// Per-timer source select: picks the count-enable source named by the
// select code and blocks it while the prescaler reset is held.
module tmr_src_select
    import tmr_prescale_pkg::*;
(
    input  logic [2:0]          sel,
    input  logic [NUM_TAPS-1:0] tap_pulse,
    input  logic                pin_rise,
    input  logic                pin_fall,
    input  logic                hold,
    output logic                cnt_en
);
    logic picked;

    // Decode the select code into one source.
    always_comb begin
        case (clk_sel_e'(sel))
            CS_FULL:     picked = 1'b1;
            CS_DIV_A:    picked = tap_pulse[0];
            CS_DIV_B:    picked = tap_pulse[1];
            CS_DIV_C:    picked = tap_pulse[2];
            CS_DIV_D:    picked = tap_pulse[3];
            CS_EXT_FALL: picked = pin_fall;
            CS_EXT_RISE: picked = pin_rise;
            default:     picked = 1'b0;
        endcase
    end

    assign cnt_en = picked & ~hold;

endmodule

// File: rtl/tmr_prescale_top.sv
// Top: control register, shared divider, and one pin sampler plus one
// source select per timer.
module tmr_prescale_top
    import tmr_prescale_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ext_pin0,
    input  logic             ext_pin1,
    input  logic [2:0]       clk_sel0,
    input  logic [2:0]       clk_sel1,
    output logic             cnt_en0,
    output logic             cnt_en1
);
    logic                presc_hold;
    logic [NUM_TAPS-1:0] taps;
    logic [NUM_TMRS-1:0] pins;
    logic [NUM_TMRS-1:0] rises;
    logic [NUM_TMRS-1:0] falls;
    logic [NUM_TMRS-1:0] ens;
    logic [2:0]          sels [NUM_TMRS];

    assign pins    = {ext_pin1, ext_pin0};
    assign sels[0] = clk_sel0;
    assign sels[1] = clk_sel1;
    assign cnt_en0 = ens[0];
    assign cnt_en1 = ens[1];

    tmr_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .presc_hold (presc_hold)
    );

    tmr_divider #(.CNT_W(CNT_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (presc_hold),
        .tap_pulse (taps)
    );

    // One pin sampler and one source select for each timer.
    for (genvar i = 0; i < NUM_TMRS; i++) begin : g_tmr
        tmr_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[i]),
            .rise  (rises[i]),
            .fall  (falls[i])
        );
        tmr_src_select u_sel (
            .sel       (sels[i]),
            .tap_pulse (taps),
            .pin_rise  (rises[i]),
            .pin_fall  (falls[i]),
            .hold      (presc_hold),
            .cnt_en    (ens[i])
        );
    end

endmodule

// File: rtl/tmr_prescale_chk.sv
// Property checker for tmr_prescale_top, attached by bind. It observes
// ports only.
module tmr_prescale_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic [2:0] clk_sel0,
    input logic [2:0] clk_sel1,
    input logic       cnt_en0,
    input logic       cnt_en1
);
    // R2: bits 5..1 read as zero.
    a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:1] == 5'd0);

    // R3: select 0 never enables.
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel0 == 3'd0) |-> !cnt_en0);

    // R3: select 1 enables whenever reset is not held.
    a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel1 == 3'd1 && !rd_data[0]) |-> cnt_en1);

    // R4: tap pulses last a single cycle.
    a_r4_tap_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel0 >= 3'd2 && clk_sel0 <= 3'd5 && cnt_en0) |=>
        (!cnt_en0 || clk_sel0 != $past(clk_sel0)));

    // R5: pin pulses last a single cycle.
    a_r5_pin_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel1 >= 3'd6 && cnt_en1) |=>
        (!cnt_en1 || clk_sel1 != $past(clk_sel1)));

    // R6: outside sync mode the reset flag clears itself.
    a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && rd_data[0] && !wr_en) |=> !rd_data[0]);

    // R7: inside sync mode the reset flag is held.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && rd_data[0] && !wr_en) |=> rd_data[0]);

    // R7: no enable while the reset flag is set.
    a_r7_halted: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] |-> (!cnt_en0 && !cnt_en1));

    // R8: equal tap selects give equal enables.
    a_r8_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel0 == clk_sel1 && clk_sel0 >= 3'd1 && clk_sel0 <= 3'd5)
        |-> (cnt_en0 == cnt_en1));

endmodule

bind tmr_prescale_top tmr_prescale_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .clk_sel0 (clk_sel0),
    .clk_sel1 (clk_sel1),
    .cnt_en0  (cnt_en0),
    .cnt_en1  (cnt_en1)
);

// File: tb/test_tmr_prescale_top.sv
// Directed bench for tmr_prescale_top: one task per scenario.
module test_tmr_prescale_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_pin0 = 1'b0;
    logic       ext_pin1 = 1'b0;
    logic [2:0] clk_sel0 = 3'd0;
    logic [2:0] clk_sel1 = 3'd0;
    logic       cnt_en0;
    logic       cnt_en1;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    tmr_prescale_top i_tmr_prescale_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ext_pin0 (ext_pin0),
        .ext_pin1 (ext_pin1),
        .clk_sel0 (clk_sel0),
        .clk_sel1 (clk_sel1),
        .cnt_en0  (cnt_en0),
        .cnt_en1  (cnt_en1)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write the register; returns at the first falling edge after the write edge.
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        check("R1 reg after reset", int'(rd_data), 0);
        check("R1 en0 after reset", int'(cnt_en0), 0);
        check("R1 en1 after reset", int'(cnt_en1), 0);
    endtask

    task automatic t_readback();
        // R2: capture flag stored; bits 5..1 always zero
        wr(8'h40);
        check("R2 capture bit readback", int'(rd_data), 8'h40);
        wr(8'hFE);
        check("R2 unused bits read zero", int'(rd_data), 8'hC0);
        wr(8'h00);
        check("R2 cleared", int'(rd_data), 0);
    endtask

    task automatic t_stop_full();
        int c0 = 0;
        int c1 = 0;
        // R3: select 0 silent, select 1 every cycle
        clk_sel0 = 3'd0;
        clk_sel1 = 3'd1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            c0 += int'(cnt_en0);
            c1 += int'(cnt_en1);
        end
        check("R3 select 0 pulses", c0, 0);
        check("R3 select 1 pulses", c1, 40);
    endtask

    task automatic t_taps();
        // R4: pulse counts over a 2048-cycle window
        for (int s = 2; s <= 5; s++) begin
            int c = 0;
            clk_sel0 = 3'(s);
            @(negedge clk);
            for (int i = 0; i < 2048; i++) begin
                @(negedge clk);
                c += int'(cnt_en0);
            end
            check($sformatf("R4 tap select %0d pulses", s), c, 2048 >> (3 * (s - 1) - ((s >= 4) ? (s - 3) : 0)));
        end
    endtask

    task automatic t_pins();
        int pos0 = -1;
        int c0 = 0;
        int c1 = 0;
        int pos1 = -1;
        // R5: rise on timer 0 (select 7), fall on timer 1 (select 6)
        clk_sel0 = 3'd7;
        clk_sel1 = 3'd6;
        repeat (4) @(negedge clk);
        ext_pin0 = 1'b1;
        ext_pin1 = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (cnt_en0) begin c0++; pos0 = i; end
            c1 += int'(cnt_en1);
        end
        check("R5 rise pulses", c0, 1);
        check("R5 rise pulse cycle", pos0, 2);
        check("R5 falling select ignores rise", c1, 0);
        c0 = 0;
        c1 = 0;
        ext_pin0 = 1'b0;
        ext_pin1 = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            c0 += int'(cnt_en0);
            if (cnt_en1) begin c1++; pos1 = i; end
        end
        check("R5 fall pulses", c1, 1);
        check("R5 fall pulse cycle", pos1, 2);
        check("R5 rising select ignores fall", c0, 0);
    endtask

    task automatic t_oneshot();
        int first = -1;
        // R6: one-cycle divider reset outside sync mode
        clk_sel0 = 3'd2;
        clk_sel1 = 3'd0;
        wr(8'h01);
        check("R6 reset flag set", int'(rd_data), 1);
        check("R6 enable blocked", int'(cnt_en0), 0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) check("R6 flag self-clears", int'(rd_data), 0);
            if (cnt_en0 && first < 0) first = k;
        end
        check("R6 first tap pulse cycle", first, 8);
    endtask

    task automatic t_sync();
        int hits = 0;
        int mism = 0;
        int first = -1;
        // R7: hold both timers
        clk_sel0 = 3'd1;
        clk_sel1 = 3'd7;
        wr(8'h81);
        check("R7 register holds flag", int'(rd_data), 8'h81);
        for (int i = 0; i < 24; i++) begin
            if (i % 4 == 0) ext_pin1 = ~ext_pin1;
            @(negedge clk);
            hits += int'(cnt_en0) + int'(cnt_en1);
        end
        check("R7 enables while held", hits, 0);
        check("R7 flag still set", int'(rd_data), 8'h81);
        // R8: release both on one edge
        clk_sel0 = 3'd2;
        clk_sel1 = 3'd2;
        wr(8'h00);
        check("R8 flag cleared on release", int'(rd_data), 0);
        for (int k = 0; k < 64; k++) begin
            if (k > 0) @(negedge clk);
            if (cnt_en0 != cnt_en1) mism++;
            if (cnt_en0 && first < 0) first = k;
        end
        check("R8 timers in step", mism, 0);
        check("R8 first pulse after release", first, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_stop_full();
        t_taps();
        t_pins();
        t_oneshot();
        t_sync();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule